// File: doc/BRIEF.md
# LRU Stack-Distance Utility Monitor

This block estimates how well one core would use every possible way allocation of a set-associative cache. It observes the core's access stream and keeps its own directory of tags, one true-LRU ordered list per set, sized for a K-way cache. Each access is looked up in the list for its set. The block then bumps the counter for the recency position where the tag sat, or a miss counter if the tag was absent. Because LRU has the inclusion property, a single pass gives the hit count of every smaller allocation: an n-way cache would have hit exactly the accesses that landed in the n most recent positions.

A partitioning controller reads the result through a combinational port. It can fetch any single counter, or ask for the hits and misses an n-way allocation would have seen. An epoch pulse halves every counter in one cycle so that old behaviour fades. A clear input zeroes the counters and leaves the tag lists alone. Accesses arrive with a valid/ready pair. Ready drops for one cycle only when an access targets the same set as the access accepted in the cycle before it.

Top module: `utilMonitor`

## Requirements
- R1: The block holds K+1 saturating counters, where K = WAYS. A read index j in 0..K-1 returns the counter for recency position j, with 0 the most recently used entry and K-1 the least recently used. Index K returns the miss counter. Any index above K reads as 0.
- R2: An access whose tag is valid at position i of its set's list increments counter i only. No other counter changes.
- R3: An access whose tag is absent from its set's list, or present only in an invalid entry, increments the miss counter (index K) only.
- R4: On a hit, the tag moves to position 0 and the entries that were above its old position each move down one place. On a miss, the new tag enters at position 0 and the entry at position K-1 is discarded. Each set's list changes only on accesses to that set.
- R5: A counter at 2^CNT_W-1 holds that value when incremented again.
- R6: `epochPulse` replaces every counter with its value divided by two, rounded down, in one cycle. An increment landing in the same cycle is applied to the halved value.
- R7: `clearAll` zeroes every counter in one cycle. It overrides a concurrent epoch and a concurrent increment. The tag lists are not changed.
- R8: An access accepted at clock edge k appears in the counters after edge k+2, and not before.
- R9: `accReady` is low exactly when an access was accepted at the previous edge and the offered `accSet` equals that access's set. An access offered while `accReady` is low is not taken.
- R10: For `rdAlloc` = n in 0..K, `rdHits` is the sum of counters 0..n-1 and `rdMisses` is the sum of counters n..K. For n above K, `rdHits` is the sum of all counters and `rdMisses` is 0.
- R11: After reset, every list entry is invalid, every counter is zero, and `accReady` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access offered this cycle |
| accSet | input | SET_W | Set index of the access |
| accTag | input | TAG_W | Tag of the access |
| accReady | output | 1 | Access is taken at the next edge when valid |
| epochPulse | input | 1 | Halve all counters |
| clearAll | input | 1 | Zero all counters |
| rdIdx | input | IDX_W | Counter select for the raw read |
| rdCount | output | CNT_W | Selected counter value |
| rdAlloc | input | IDX_W | Way allocation n for the prefix sums |
| rdHits | output | SUM_W | Hits an n-way allocation would have seen |
| rdMisses | output | SUM_W | Misses an n-way allocation would have seen |

## Verification
A corrupted recency list does not show up straight away. It appears later, on an access to the same set, as a count in the wrong position, and it can surface many accesses after the fault. For that reason the sweep replays long, reuse-heavy streams and compares every counter and every prefix sum. A wrong counter update, by contrast, shows at the read port two edges after the access is accepted. A wrong ready decision shows the same cycle, as an access that stalls when it should not or as a stale list read that shifts later counts.

// File: rtl/utilMonPkg.sv
package utilMonPkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic capture;  // accept offered access into stage 1
    logic lookup;   // read the set's list into stage 2
    logic commit;   // write back the list and bump a counter
    logic halve;    // epoch decay
    logic wipe;     // zero all counters
  } monStrobe_t;

endpackage

// File: rtl/utilMonCtrl.sv
module utilMonCtrl
  import utilMonPkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [SET_W-1:0] accSet,
  input  logic [SET_W-1:0] s1Set,
  input  logic             epochPulse,
  input  logic             clearAll,
  output logic             accReady,
  output monStrobe_t       strobe
);

  logic s1Valid;
  logic s2Valid;

  // A same-set access right behind another would read the list before
  // the earlier access writes it back, so hold it off for one cycle.
  assign accReady = !(s1Valid && (s1Set == accSet));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= accValid && accReady;
      s2Valid <= s1Valid;
    end
  end

  always_comb begin
    strobe.capture = accValid && accReady;
    strobe.lookup  = s1Valid;
    strobe.commit  = s2Valid;
    strobe.halve   = epochPulse;
    strobe.wipe    = clearAll;
  end

endmodule

// File: rtl/utilMonStack.sv
module utilMonStack
  import utilMonPkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  localparam int SET_W = $clog2(SETS),
  localparam int IDX_W = $clog2(WAYS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  monStrobe_t       strobe,
  input  logic [SET_W-1:0] accSet,
  input  logic [TAG_W-1:0] accTag,
  output logic [SET_W-1:0] s1Set,
  output logic             bumpValid,
  output logic [IDX_W-1:0] bumpIdx,
  output logic             hitFound
);

  // Recency lists: entry 0 is most recent, entry WAYS-1 least recent
  logic [TAG_W-1:0] tagMem [SETS][WAYS];
  logic [WAYS-1:0]  vldMem [SETS];

  logic [TAG_W-1:0] s1Tag;
  logic [SET_W-1:0] s2Set;
  logic [TAG_W-1:0] s2Tag;
  logic [TAG_W-1:0] s2Row [WAYS];
  logic [WAYS-1:0]  s2Vld;

  logic [WAYS-1:0]  hitVec;
  logic [IDX_W-1:0] depth;
  logic [TAG_W-1:0] nextRow [WAYS];
  logic [WAYS-1:0]  nextVld;

  // Stage registers with reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Set <= '0;
      s2Set <= '0;
      s2Vld <= '0;
      for (int s = 0; s < SETS; s++) vldMem[s] <= '0;
    end else begin
      if (strobe.capture) s1Set <= accSet;
      if (strobe.lookup) begin
        s2Set <= s1Set;
        s2Vld <= vldMem[s1Set];
      end
      if (strobe.commit) vldMem[s2Set] <= nextVld;
    end
  end

  // Tag storage and tag pipeline, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.capture) s1Tag <= accTag;
    if (strobe.lookup) begin
      s2Tag <= s1Tag;
      for (int w = 0; w < WAYS; w++) s2Row[w] <= tagMem[s1Set][w];
    end
    if (strobe.commit) begin
      for (int w = 0; w < WAYS; w++) tagMem[s2Set][w] <= nextRow[w];
    end
  end

  // One comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = s2Vld[w] && (s2Row[w] == s2Tag);
  end

  // Stack depth of the match, WAYS when absent
  always_comb begin
    depth = IDX_W'(WAYS);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) depth = IDX_W'(w);
    end
  end

  // Move-to-front: entries above the old depth slide down; on a miss the
  // depth is WAYS so every entry slides and the last one falls off.
  always_comb begin
    nextRow[0] = s2Tag;
    nextVld[0] = 1'b1;
    for (int w = 1; w < WAYS; w++) begin
      if (IDX_W'(w) <= depth) begin
        nextRow[w] = s2Row[w-1];
        nextVld[w] = s2Vld[w-1];
      end else begin
        nextRow[w] = s2Row[w];
        nextVld[w] = s2Vld[w];
      end
    end
  end

  assign bumpValid = strobe.commit;
  assign bumpIdx   = depth;
  assign hitFound  = |hitVec;

endmodule

// File: rtl/utilMonCounters.sv
module utilMonCounters
  import utilMonPkg::*;
#(
  parameter int WAYS  = 4,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(WAYS + 1),
  localparam int SUM_W = CNT_W + IDX_W,
  localparam int NCNT  = WAYS + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  monStrobe_t            strobe,
  input  logic                  bumpValid,
  input  logic [IDX_W-1:0]      bumpIdx,
  input  logic [IDX_W-1:0]      rdIdx,
  input  logic [IDX_W-1:0]      rdAlloc,
  output logic [CNT_W-1:0]      rdCount,
  output logic [SUM_W-1:0]      rdHits,
  output logic [SUM_W-1:0]      rdMisses,
  output logic [NCNT*CNT_W-1:0] cntFlat
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar j = 0; j < NCNT; j++) begin : g_cnt
    logic [CNT_W-1:0] value;
    logic [CNT_W-1:0] base;
    logic             mine;

    assign base = strobe.halve ? (value >> 1) : value;
    assign mine = bumpValid && (bumpIdx == IDX_W'(j));

    always_ff @(posedge clk) begin
      if (!rstN)                         value <= '0;
      else if (strobe.wipe)              value <= '0;
      else if (mine && base != CNT_MAX)  value <= base + 1'b1;
      else                               value <= base;
    end

    assign cntFlat[j*CNT_W +: CNT_W] = value;
  end

  // Raw counter read
  always_comb begin
    rdCount = '0;
    for (int j = 0; j < NCNT; j++) begin
      if (rdIdx == IDX_W'(j)) rdCount = cntFlat[j*CNT_W +: CNT_W];
    end
  end

  // Prefix sums for an n-way allocation
  always_comb begin
    rdHits   = '0;
    rdMisses = '0;
    for (int j = 0; j < NCNT; j++) begin
      if (IDX_W'(j) < rdAlloc)
        rdHits = rdHits + SUM_W'(cntFlat[j*CNT_W +: CNT_W]);
      else
        rdMisses = rdMisses + SUM_W'(cntFlat[j*CNT_W +: CNT_W]);
    end
  end

endmodule

// File: rtl/utilMonitor.sv
module utilMonitor
  import utilMonPkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  parameter int CNT_W = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int IDX_W = $clog2(WAYS + 1),
  localparam int SUM_W = CNT_W + IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [SET_W-1:0] accSet,
  input  logic [TAG_W-1:0] accTag,
  output logic             accReady,
  input  logic             epochPulse,
  input  logic             clearAll,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0] rdCount,
  input  logic [IDX_W-1:0] rdAlloc,
  output logic [SUM_W-1:0] rdHits,
  output logic [SUM_W-1:0] rdMisses
);

  monStrobe_t                    strobe;
  logic [SET_W-1:0]              s1Set;
  logic                          bumpValid;
  logic [IDX_W-1:0]              bumpIdx;
  logic                          hitFound;
  logic [(WAYS+1)*CNT_W-1:0]     cntFlat;

  utilMonCtrl #(.SET_W(SET_W)) uCtrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet),
    .s1Set(s1Set), .epochPulse(epochPulse), .clearAll(clearAll),
    .accReady(accReady), .strobe(strobe)
  );

  utilMonStack #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) uStack (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accSet(accSet),
    .accTag(accTag), .s1Set(s1Set), .bumpValid(bumpValid),
    .bumpIdx(bumpIdx), .hitFound(hitFound)
  );

  utilMonCounters #(.WAYS(WAYS), .CNT_W(CNT_W)) uCnt (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bumpValid(bumpValid),
    .bumpIdx(bumpIdx), .rdIdx(rdIdx), .rdAlloc(rdAlloc),
    .rdCount(rdCount), .rdHits(rdHits), .rdMisses(rdMisses),
    .cntFlat(cntFlat)
  );

endmodule

// File: rtl/utilMonChecker.sv
module utilMonChecker #(
  parameter int WAYS  = 4,
  parameter int SET_W = 4,
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      accValid,
  input logic                      accReady,
  input logic [SET_W-1:0]          accSet,
  input logic                      epochPulse,
  input logic                      clearAll,
  input logic                      bumpValid,
  input logic [IDX_W-1:0]          bumpIdx,
  input logic                      hitFound,
  input logic [(WAYS+1)*CNT_W-1:0] cntFlat
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] missCnt;
  logic [CNT_W-1:0] mruCnt;
  assign missCnt = cntFlat[WAYS*CNT_W +: CNT_W];
  assign mruCnt  = cntFlat[0 +: CNT_W];

  // R9
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accReady |-> ($past(accValid && accReady) && ($past(accSet) == accSet)));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (cntFlat == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bumpValid && !epochPulse && !clearAll) |=> $stable(cntFlat));

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bumpValid |-> (bumpIdx <= IDX_W'(WAYS)));

  // R3
  hit_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bumpValid && hitFound) |-> (bumpIdx < IDX_W'(WAYS)));

  // R5
  miss_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missCnt == CNT_MAX && !epochPulse && !clearAll) |=> (missCnt == CNT_MAX));

  // R6
  halve_chk: assert property (@(posedge clk) disable iff (!rstN)
    (epochPulse && !clearAll && !bumpValid) |=> (mruCnt == ($past(mruCnt) >> 1)));

endmodule

bind utilMonitor utilMonChecker #(
  .WAYS(WAYS), .SET_W(SET_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) uChk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accReady(accReady),
  .accSet(accSet), .epochPulse(epochPulse), .clearAll(clearAll),
  .bumpValid(bumpValid), .bumpIdx(bumpIdx), .hitFound(hitFound),
  .cntFlat(cntFlat)
);

// File: tb/tb_utilMonitor.sv
module tb_utilMonitor;

  localparam int WAYS  = 4;
  localparam int SETS  = 4;
  localparam int TAG_W = 6;
  localparam int CNT_W = 8;
  localparam int SET_W = 2;
  localparam int IDX_W = 3;
  localparam int SUM_W = CNT_W + IDX_W;
  localparam int MAXV  = 255;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             accValid = 1'b0;
  logic [SET_W-1:0] accSet = '0;
  logic [TAG_W-1:0] accTag = '0;
  logic             accReady;
  logic             epochPulse = 1'b0;
  logic             clearAll = 1'b0;
  logic [IDX_W-1:0] rdIdx = '0;
  logic [CNT_W-1:0] rdCount;
  logic [IDX_W-1:0] rdAlloc = '0;
  logic [SUM_W-1:0] rdHits;
  logic [SUM_W-1:0] rdMisses;

  int tests = 0;
  int failed = 0;
  bit done = 0;

  // Reference model built from the requirements
  int mTag [SETS][WAYS];
  bit mVld [SETS][WAYS];
  int mCnt [WAYS+1];

  always #10 clk = ~clk;

  utilMonitor #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet),
    .accTag(accTag), .accReady(accReady), .epochPulse(epochPulse),
    .clearAll(clearAll), .rdIdx(rdIdx), .rdCount(rdCount),
    .rdAlloc(rdAlloc), .rdHits(rdHits), .rdMisses(rdMisses)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelStack(input int s, input int t, output int pos);
    pos = WAYS;
    for (int w = WAYS - 1; w >= 0; w--)
      if (mVld[s][w] && mTag[s][w] == t) pos = w;
    for (int w = WAYS - 1; w >= 1; w--)
      if (w <= pos) begin
        mTag[s][w] = mTag[s][w-1];
        mVld[s][w] = mVld[s][w-1];
      end
    mTag[s][0] = t;
    mVld[s][0] = 1;
  endtask

  task automatic modelBump(input int pos);
    if (mCnt[pos] < MAXV) mCnt[pos]++;
  endtask

  task automatic modelHalve();
    for (int j = 0; j <= WAYS; j++) mCnt[j] = mCnt[j] / 2;
  endtask

  task automatic doAccess(input int s, input int t);
    int pos;
    @(negedge clk);
    accValid = 1'b1; accSet = SET_W'(s); accTag = TAG_W'(t);
    #1;
    while (!accReady) begin @(negedge clk); #1; end
    modelStack(s, t, pos);
    modelBump(pos);
  endtask

  task automatic settle();
    @(negedge clk);
    accValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkAll(input string req);
    for (int j = 0; j <= WAYS; j++) begin
      rdIdx = IDX_W'(j); #1;
      chk({req, " counter"}, int'(rdCount), mCnt[j]);
    end
    for (int n = 0; n <= WAYS; n++) begin
      int h = 0;
      int m = 0;
      for (int j = 0; j <= WAYS; j++) if (j < n) h += mCnt[j]; else m += mCnt[j];
      rdAlloc = IDX_W'(n); #1;
      chk("R10 hits", int'(rdHits), h);
      chk("R10 misses", int'(rdMisses), m);
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    int pos;
    logic [15:0] lfsr;
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin
      mTag[s][w] = 0; mVld[s][w] = 0;
    end
    for (int j = 0; j <= WAYS; j++) mCnt[j] = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    chk("R11 ready", int'(accReady), 1);
    checkAll("R11");

    // R4 directed ordering, literal expectations
    doAccess(1, 10); doAccess(1, 11); doAccess(1, 12); doAccess(1, 13);
    doAccess(1, 10);   // LRU position 3
    doAccess(1, 10);   // MRU position 0
    doAccess(1, 14);   // miss, drops 11
    doAccess(1, 11);   // miss
    doAccess(1, 13);   // position 3
    settle();
    rdIdx = 3'd0; #1; chk("R2 pos0 hits", int'(rdCount), 1);
    rdIdx = 3'd3; #1; chk("R4 lru hits", int'(rdCount), 2);
    rdIdx = 3'd4; #1; chk("R3 misses", int'(rdCount), 6);
    rdIdx = 3'd5; #1; chk("R1 out of range", int'(rdCount), 0);
    rdIdx = 3'd7; #1; chk("R1 out of range", int'(rdCount), 0);
    rdAlloc = 3'd6; #1;
    chk("R10 over K hits", int'(rdHits), 9);
    chk("R10 over K misses", int'(rdMisses), 0);
    checkAll("R4");

    // R8 latency: set 2 fresh, so a miss
    @(negedge clk);
    accValid = 1'b1; accSet = 2'd2; accTag = 6'd33; #1;
    chk("R9 ready idle", int'(accReady), 1);
    modelStack(2, 33, pos);
    rdIdx = IDX_W'(pos);
    @(negedge clk); accValid = 1'b0; #1;
    chk("R8 after k", int'(rdCount), mCnt[pos]);
    @(negedge clk); #1;
    chk("R8 after k+1", int'(rdCount), mCnt[pos]);
    @(negedge clk); #1;
    chk("R8 after k+2", int'(rdCount), mCnt[pos] + 1);
    modelBump(pos);

    // R9 same-set stall, then other set flows
    @(negedge clk);
    accValid = 1'b1; accSet = 2'd2; accTag = 6'd34; #1;
    chk("R9 ready first", int'(accReady), 1);
    modelStack(2, 34, pos); modelBump(pos);
    @(negedge clk);
    accSet = 2'd2; accTag = 6'd35; #1;
    chk("R9 same set stall", int'(accReady), 0);
    @(negedge clk); #1;
    chk("R9 retry ready", int'(accReady), 1);
    modelStack(2, 35, pos); modelBump(pos);
    @(negedge clk);
    accSet = 2'd3; accTag = 6'd1; #1;
    chk("R9 other set ready", int'(accReady), 1);
    modelStack(3, 1, pos); modelBump(pos);
    settle();
    checkAll("R9");

    // Sweep with reuse-heavy streams
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      doAccess(int'(lfsr[1:0]), int'(lfsr[7:4]) % (i < 1500 ? 6 : 9));
    end
    settle();
    checkAll("R2 R3 sweep");

    // R6 epoch alone
    @(negedge clk); epochPulse = 1'b1;
    @(negedge clk); epochPulse = 1'b0;
    modelHalve();
    checkAll("R6 halve");

    // R6 epoch with concurrent increment
    @(negedge clk);
    accValid = 1'b1; accSet = 2'd0; accTag = 6'd2; #1;
    modelStack(0, 2, pos);
    @(negedge clk); accValid = 1'b0;
    @(negedge clk); epochPulse = 1'b1;
    @(negedge clk); epochPulse = 1'b0;
    modelHalve(); modelBump(pos);
    checkAll("R6 concurrent");

    // R7 clear overrides epoch and increment, lists kept
    @(negedge clk);
    accValid = 1'b1; accSet = 2'd0; accTag = 6'd7; #1;
    modelStack(0, 7, pos);
    @(negedge clk); accValid = 1'b0;
    @(negedge clk); epochPulse = 1'b1; clearAll = 1'b1;
    @(negedge clk); epochPulse = 1'b0; clearAll = 1'b0;
    for (int j = 0; j <= WAYS; j++) mCnt[j] = 0;
    checkAll("R7 clear");
    doAccess(0, 7);
    settle();
    rdIdx = 3'd0; #1; chk("R7 list kept", int'(rdCount), 1);
    checkAll("R7");

    // R5 saturation
    @(negedge clk); clearAll = 1'b1;
    @(negedge clk); clearAll = 1'b0;
    for (int j = 0; j <= WAYS; j++) mCnt[j] = 0;
    for (int i = 0; i < 262; i++) doAccess(3, 20);
    settle();
    rdIdx = 3'd0; #1; chk("R5 saturate", int'(rdCount), MAXV);
    checkAll("R5");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule